// File: doc/BRIEF.md
# Nibble Accumulator Execution Core

This block is the execute stage of a small 4-bit accumulator machine. In every clock cycle it decodes one 16-bit instruction word and commits the results at the next rising edge. The state it can change is the accumulator, three general registers (RA, RB, RC), a carry flag and a zero flag, and four 4-bit output port latches. There is no microcode. A 2-bit modifier field and an addressing-mode bit choose the source and the destination of each operation.

Data memory sits outside the block. An external address unit builds the address, and this core tells it which kind of access the current instruction uses, absolute or register-indirect. Read data returns on a 4-bit port in the same cycle. For a store, the core raises a write strobe and presents the accumulator as write data in the same cycle. The program counter, jumps and address composition belong to neighbouring blocks.

Top module: `nibble_exec_core`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, RA, RB, RC, both flags and all four port latches to zero at the next rising edge.
- R2: The instruction word fields are: bit 15 opcode extension (must be 0), bit 14 addressing mode, bits 13:12 modifier, bits 11:8 opcode, bits 3:0 immediate. Opcode 0 with mode 0 loads the immediate into the accumulator, RA, RB or RC for modifier 0, 1, 2 or 3. The zero flag updates only when the accumulator is the destination.
- R3: Opcode 1 stores NAND(accumulator, operand) into the accumulator and updates only the zero flag. The operand is chosen as follows:
  - modifier 0: the immediate;
  - modifier 1: RA;
  - modifier 2: RB;
  - modifier 3: RAM read data;
  - mode bit set with modifier 3: RAM read data at the register-indirect address.
- R4: Opcode 11 stores accumulator minus operand into the accumulator, with the operand chosen as in R3. The carry flag is set exactly when the operand exceeds the accumulator (a borrow). The zero flag is set when the difference is zero.
- R5: Opcode 8 (compare) sets both flags as R4 does but leaves the accumulator unchanged.
- R6: Opcode 2 with modifier 0 loads RAM read data into the accumulator. Opcode 3 with mode 0 loads RA, RB or RC into the accumulator for modifier 1, 2 or 3. Both update the zero flag and keep the carry flag.
- R7: Opcode 7 with mode 0 copies the accumulator into RA, RB or RC for modifier 1, 2 or 3, and leaves both flags untouched.
- R8: Opcodes 4, 5, 6 and 9 latch a value into port A, B, C and D respectively; the other ports and both flags hold. The modifier chooses the value:
  - modifier 0: the immediate;
  - modifier 1: the accumulator;
  - modifier 2: RA;
  - modifier 3: RAM read data;
  - mode bit set with modifier 3: RAM read data at the register-indirect address.
- R9: Opcode 10 with modifier 0 raises `ramWrEn` in the same cycle, with `ramWrData` equal to the accumulator. It leaves all registers and flags untouched. No other instruction raises `ramWrEn`.
- R10: `ramIndirect` is 1 exactly when a valid RAM-using instruction has the mode bit set. This covers modifier 3 for opcodes 1, 4, 5, 6, 8, 9 and 11, and modifier 0 for opcodes 2 and 10. It is 0 for the absolute form.
- R11: Every other combination is a no-operation and changes no register, flag, port or RAM. This includes bit 15 set, opcodes 12 to 15, modifier 0 for opcodes 3 and 7, a set mode bit outside the combinations listed in R10, and modifiers 1 to 3 for opcodes 2 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instrWord | input | 16 | Instruction executed this cycle |
| ramRdData | input | 4 | RAM read data for this cycle's access |
| ramIndirect | output | 1 | Access type: 1 register-indirect, 0 absolute |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrData | output | 4 | RAM write data (accumulator) |
| accQ | output | 4 | Accumulator |
| regA | output | 4 | Register RA |
| regB | output | 4 | Register RB |
| regC | output | 4 | Register RC |
| carryFlag | output | 1 | Carry/borrow flag |
| zeroFlag | output | 1 | Zero flag |
| portA | output | 4 | Output port A latch |
| portB | output | 4 | Output port B latch |
| portC | output | 4 | Output port C latch |
| portD | output | 4 | Output port D latch |

## Verification
`ramWrEn`, `ramWrData` and `ramIndirect` come from the instruction presented in the same cycle. Registers, flags and port latches show the result one rising edge after their instruction. The driver applies each instruction on a falling edge and checks the memory strobes 1 ns later, before the edge. It then queues the expected register state. The monitor pops that entry 2 ns after the following rising edge, so every comparison falls exactly one register stage behind its stimulus.

// File: rtl/nibble_exec_pkg.sv
package nibble_exec_pkg;

  localparam int NIB_W     = 4;
  localparam int INSTR_W   = 16;
  localparam int NUM_GPR   = 3;
  localparam int NUM_PORTS = 4;
  localparam int OP_W      = 4;

  localparam logic [OP_W-1:0] OP_LDI  = 4'h0;
  localparam logic [OP_W-1:0] OP_NAND = 4'h1;
  localparam logic [OP_W-1:0] OP_LDW  = 4'h2;
  localparam logic [OP_W-1:0] OP_LDA  = 4'h3;
  localparam logic [OP_W-1:0] OP_OUTA = 4'h4;
  localparam logic [OP_W-1:0] OP_OUTB = 4'h5;
  localparam logic [OP_W-1:0] OP_OUTC = 4'h6;
  localparam logic [OP_W-1:0] OP_LDR  = 4'h7;
  localparam logic [OP_W-1:0] OP_CMP  = 4'h8;
  localparam logic [OP_W-1:0] OP_OUTD = 4'h9;
  localparam logic [OP_W-1:0] OP_STW  = 4'hA;
  localparam logic [OP_W-1:0] OP_SUB  = 4'hB;

  typedef enum logic [2:0] {
    SRC_IMM, SRC_ACC, SRC_RA, SRC_RB, SRC_RC, SRC_RAM
  } src_e;

  typedef enum logic [1:0] {
    FN_PASS, FN_NAND, FN_SUB
  } fn_e;

  typedef struct packed {
    logic                 accWr;
    fn_e                  aluFn;
    src_e                 srcSel;
    logic                 flagZWr;
    logic                 flagCWr;
    logic [NUM_GPR-1:0]   regWr;
    logic                 regFromAcc;
    logic [NUM_PORTS-1:0] portWr;
    logic                 ramWr;
    logic                 ramIndirect;
  } ctrl_t;

endpackage

// File: rtl/nibble_exec_ctrl.sv
module nibble_exec_ctrl
  import nibble_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instrWord,
  output ctrl_t              ctrl
);

  logic            extBit;
  logic            modeBit;
  logic [1:0]      modSel;
  logic [OP_W-1:0] opField;
  logic            plainOk;
  logic            operandOk;
  logic            wordOk;
  logic            regPick;
  logic [NUM_GPR-1:0]   gprMask;
  logic [NUM_PORTS-1:0] portMask;

  assign extBit  = instrWord[15];
  assign modeBit = instrWord[14];
  assign modSel  = instrWord[13:12];
  assign opField = instrWord[11:8];

  // legal combinations per instruction class
  assign plainOk   = !extBit && !modeBit;
  assign operandOk = !extBit && (!modeBit || modSel == 2'd3);
  assign wordOk    = !extBit && modSel == 2'd0;
  assign regPick   = plainOk && modSel != 2'd0;

  assign gprMask = NUM_GPR'(1) << (modSel - 2'd1);

  always_comb begin
    case (opField)
      OP_OUTA: portMask = NUM_PORTS'(1);
      OP_OUTB: portMask = NUM_PORTS'(2);
      OP_OUTC: portMask = NUM_PORTS'(4);
      default: portMask = NUM_PORTS'(8);
    endcase
  end

  function automatic src_e operandOf(input logic [1:0] m);
    case (m)
      2'd0:    return SRC_IMM;
      2'd1:    return SRC_RA;
      2'd2:    return SRC_RB;
      default: return SRC_RAM;
    endcase
  endfunction

  function automatic src_e portSrcOf(input logic [1:0] m);
    case (m)
      2'd0:    return SRC_IMM;
      2'd1:    return SRC_ACC;
      2'd2:    return SRC_RA;
      default: return SRC_RAM;
    endcase
  endfunction

  function automatic src_e gprOf(input logic [1:0] m);
    case (m)
      2'd1:    return SRC_RA;
      2'd2:    return SRC_RB;
      default: return SRC_RC;
    endcase
  endfunction

  always_comb begin
    ctrl        = '0;
    ctrl.srcSel = SRC_IMM;
    ctrl.aluFn  = FN_PASS;
    case (opField)
      OP_LDI: begin
        if (plainOk) begin
          if (modSel == 2'd0) begin
            ctrl.accWr   = 1'b1;
            ctrl.flagZWr = 1'b1;
          end else begin
            ctrl.regWr = gprMask;
          end
        end
      end
      OP_NAND, OP_CMP, OP_SUB: begin
        if (operandOk) begin
          ctrl.srcSel      = modeBit ? SRC_RAM : operandOf(modSel);
          ctrl.aluFn       = (opField == OP_NAND) ? FN_NAND : FN_SUB;
          ctrl.accWr       = (opField != OP_CMP);
          ctrl.flagZWr     = 1'b1;
          ctrl.flagCWr     = (opField != OP_NAND);
          ctrl.ramIndirect = modeBit;
        end
      end
      OP_LDW: begin
        if (wordOk) begin
          ctrl.srcSel      = SRC_RAM;
          ctrl.accWr       = 1'b1;
          ctrl.flagZWr     = 1'b1;
          ctrl.ramIndirect = modeBit;
        end
      end
      OP_STW: begin
        if (wordOk) begin
          ctrl.ramWr       = 1'b1;
          ctrl.ramIndirect = modeBit;
        end
      end
      OP_LDA: begin
        if (regPick) begin
          ctrl.srcSel  = gprOf(modSel);
          ctrl.accWr   = 1'b1;
          ctrl.flagZWr = 1'b1;
        end
      end
      OP_LDR: begin
        if (regPick) begin
          ctrl.regWr      = gprMask;
          ctrl.regFromAcc = 1'b1;
        end
      end
      OP_OUTA, OP_OUTB, OP_OUTC, OP_OUTD: begin
        if (operandOk) begin
          ctrl.srcSel      = modeBit ? SRC_RAM : portSrcOf(modSel);
          ctrl.portWr      = portMask;
          ctrl.ramIndirect = modeBit;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/nibble_exec_alu.sv
module nibble_exec_alu
  import nibble_exec_pkg::*;
#(
  parameter int DATA_W = NIB_W
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  fn_e               aluFn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam int SUM_W = DATA_W + 1;

  logic             invB;
  logic [SUM_W-1:0] sumFull;

  // one adder serves both add and subtract; subtract inverts B and adds one
  assign invB    = (aluFn == FN_SUB);
  assign sumFull = {1'b0, opA} + {1'b0, opB ^ {DATA_W{invB}}} + SUM_W'(invB);
  // carry for add, borrow (no carry) for subtract
  assign carryOut = sumFull[DATA_W] ^ invB;

  always_comb begin
    case (aluFn)
      FN_NAND: result = ~(opA & opB);
      FN_SUB:  result = sumFull[DATA_W-1:0];
      default: result = opB;
    endcase
  end

endmodule

// File: rtl/nibble_exec_dp.sv
module nibble_exec_dp
  import nibble_exec_pkg::*;
#(
  parameter int DATA_W = NIB_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  ctrl_t                             ctrl,
  input  logic [DATA_W-1:0]                 immVal,
  input  logic [DATA_W-1:0]                 ramRdData,
  output logic [DATA_W-1:0]                 accQ,
  output logic [NUM_GPR-1:0][DATA_W-1:0]    gprQ,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  portQ,
  output logic                              carryFlag,
  output logic                              zeroFlag,
  output logic [DATA_W-1:0]                 ramWrData
);

  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] aluRes;
  logic              aluCarry;
  logic [DATA_W-1:0] gprIn;

  always_comb begin
    case (ctrl.srcSel)
      SRC_ACC: srcVal = accQ;
      SRC_RA:  srcVal = gprQ[0];
      SRC_RB:  srcVal = gprQ[1];
      SRC_RC:  srcVal = gprQ[2];
      SRC_RAM: srcVal = ramRdData;
      default: srcVal = immVal;
    endcase
  end

  nibble_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .opA      (accQ),
    .opB      (srcVal),
    .aluFn    (ctrl.aluFn),
    .result   (aluRes),
    .carryOut (aluCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ      <= '0;
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
    end else begin
      if (ctrl.accWr)   accQ      <= aluRes;
      if (ctrl.flagZWr) zeroFlag  <= (aluRes == '0);
      if (ctrl.flagCWr) carryFlag <= aluCarry;
    end
  end

  assign gprIn = ctrl.regFromAcc ? accQ : immVal;

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)                gprQ[g] <= '0;
      else if (ctrl.regWr[g]) gprQ[g] <= gprIn;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)                 portQ[p] <= '0;
      else if (ctrl.portWr[p]) portQ[p] <= srcVal;
    end
  end

  assign ramWrData = accQ;

endmodule

// File: rtl/nibble_exec_core.sv
module nibble_exec_core
  import nibble_exec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [NIB_W-1:0]   ramRdData,
  output logic               ramIndirect,
  output logic               ramWrEn,
  output logic [NIB_W-1:0]   ramWrData,
  output logic [NIB_W-1:0]   accQ,
  output logic [NIB_W-1:0]   regA,
  output logic [NIB_W-1:0]   regB,
  output logic [NIB_W-1:0]   regC,
  output logic               carryFlag,
  output logic               zeroFlag,
  output logic [NIB_W-1:0]   portA,
  output logic [NIB_W-1:0]   portB,
  output logic [NIB_W-1:0]   portC,
  output logic [NIB_W-1:0]   portD
);

  ctrl_t                            ctrl;
  logic [NUM_GPR-1:0][NIB_W-1:0]    gprQ;
  logic [NUM_PORTS-1:0][NIB_W-1:0]  portQ;

  nibble_exec_ctrl u_ctrl (
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  nibble_exec_dp #(.DATA_W(NIB_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .immVal    (instrWord[NIB_W-1:0]),
    .ramRdData (ramRdData),
    .accQ      (accQ),
    .gprQ      (gprQ),
    .portQ     (portQ),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag),
    .ramWrData (ramWrData)
  );

  assign ramWrEn     = ctrl.ramWr;
  assign ramIndirect = ctrl.ramIndirect;
  assign regA  = gprQ[0];
  assign regB  = gprQ[1];
  assign regC  = gprQ[2];
  assign portA = portQ[0];
  assign portB = portQ[1];
  assign portC = portQ[2];
  assign portD = portQ[3];

endmodule

// File: rtl/nibble_exec_core_chk.sv
module nibble_exec_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instrWord,
  input logic        ramIndirect,
  input logic        ramWrEn,
  input logic [3:0]  accQ,
  input logic [3:0]  regA,
  input logic [3:0]  regB,
  input logic [3:0]  regC,
  input logic        carryFlag,
  input logic        zeroFlag,
  input logic [3:0]  portA,
  input logic [3:0]  portB,
  input logic [3:0]  portC,
  input logic [3:0]  portD
);

  logic isOut;
  assign isOut = instrWord[11:8] inside {4'h4, 4'h5, 4'h6, 4'h9};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (accQ == 4'h0 && regA == 4'h0 && regB == 4'h0 && regC == 4'h0 &&
             !carryFlag && !zeroFlag && portA == 4'h0 && portB == 4'h0 &&
             portC == 4'h0 && portD == 4'h0));

  p_ldi_acc_r2: assert property (@(posedge clk) disable iff (rst)
    (instrWord[15:8] == 8'h00) |=> (accQ == $past(instrWord[3:0])));

  p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
    (instrWord[15:8] == 8'h08) |=> $stable(accQ));

  p_out_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    isOut |=> ($stable(carryFlag) && $stable(zeroFlag)));

  p_store_only_r9: assert property (@(posedge clk) disable iff (rst)
    ramWrEn |-> (instrWord[15] == 1'b0 && instrWord[11:8] == 4'hA));

  p_indirect_mode_r10: assert property (@(posedge clk) disable iff (rst)
    ramIndirect |-> instrWord[14]);

  p_ext_nop_r11: assert property (@(posedge clk) disable iff (rst)
    instrWord[15] |=> ($stable(accQ) && $stable(regA) && $stable(regB) &&
                       $stable(regC) && $stable(carryFlag) && $stable(zeroFlag) &&
                       $stable(portA) && $stable(portD)));

  p_ext_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    instrWord[15] |-> !ramWrEn);

endmodule

bind nibble_exec_core nibble_exec_core_chk u_chk (.*);

// File: tb/nibble_exec_core_bench.sv
module nibble_exec_core_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instrWord;
  logic [3:0]  ramRdData;
  logic        ramIndirect, ramWrEn;
  logic [3:0]  ramWrData, accQ, regA, regB, regC;
  logic        carryFlag, zeroFlag;
  logic [3:0]  portA, portB, portC, portD;

  always #4 clk = ~clk;

  nibble_exec_core u_nibble_exec_core (.*);

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 1'b0;

  logic [33:0] expQ[$];
  string       tagQ[$];

  // requirement-level model state
  logic [3:0] mAcc, mA, mB, mC;
  logic [3:0] mPort[4];
  logic       mCf, mZf;

  task automatic modelReset();
    mAcc = 0; mA = 0; mB = 0; mC = 0; mCf = 0; mZf = 0;
    for (int i = 0; i < 4; i++) mPort[i] = 0;
  endtask

  task automatic issue(input logic r, input logic [15:0] iw,
                       input logic [3:0] rd, input string tag);
    logic ext, md1, am;
    logic [1:0] md;
    logic [3:0] op, imm, opnd, diff;
    logic eWr, eInd;
    logic [3:0] eWrData;
    @(negedge clk);
    rst = r; instrWord = iw; ramRdData = rd;
    ext = iw[15]; am = iw[14]; md = iw[13:12]; op = iw[11:8]; imm = iw[3:0];
    md1 = (md == 2'd3);
    eWr = 0; eInd = 0; eWrData = mAcc;
    if (r) modelReset();
    else begin
      case (op)
        4'h0: if (!ext && !am) begin
          case (md)
            2'd0: begin mAcc = imm; mZf = (imm == 0); end
            2'd1: mA = imm;
            2'd2: mB = imm;
            default: mC = imm;
          endcase
        end
        4'h1, 4'h8, 4'hB: if (!ext && (!am || md1)) begin
          opnd = am ? rd : (md == 0 ? imm : md == 1 ? mA : md == 2 ? mB : rd);
          eInd = am;
          if (op == 4'h1) begin
            mAcc = ~(mAcc & opnd); mZf = (mAcc == 0);
          end else begin
            diff = mAcc - opnd;
            mCf = (opnd > mAcc); mZf = (diff == 0);
            if (op == 4'hB) mAcc = diff;
          end
        end
        4'h2: if (!ext && md == 0) begin mAcc = rd; mZf = (rd == 0); eInd = am; end
        4'hA: if (!ext && md == 0) begin eWr = 1; eInd = am; end
        4'h3: if (!ext && !am && md != 0) begin
          mAcc = (md == 1) ? mA : (md == 2) ? mB : mC; mZf = (mAcc == 0);
        end
        4'h7: if (!ext && !am && md != 0) begin
          if (md == 1) mA = mAcc; else if (md == 2) mB = mAcc; else mC = mAcc;
        end
        4'h4, 4'h5, 4'h6, 4'h9: if (!ext && (!am || md1)) begin
          opnd = am ? rd : (md == 0 ? imm : md == 1 ? mAcc : md == 2 ? mA : rd);
          eInd = am;
          mPort[op == 4'h4 ? 0 : op == 4'h5 ? 1 : op == 4'h6 ? 2 : 3] = opnd;
        end
        default: ;
      endcase
    end
    expQ.push_back({mAcc, mA, mB, mC, mPort[0], mPort[1], mPort[2], mPort[3], mCf, mZf});
    tagQ.push_back(tag);
    #1;
    if (!r) begin
      testsRun++;
      if ({ramWrEn, ramIndirect, ramWrEn ? ramWrData : 4'h0} !==
          {eWr, eInd, eWr ? eWrData : 4'h0}) begin
        testsFail++;
        $display("FAIL %s strobes: got wr=%b ind=%b data=%h exp wr=%b ind=%b data=%h",
                 tag, ramWrEn, ramIndirect, ramWrData, eWr, eInd, eWrData);
      end
    end
  endtask

  // monitor: one queued expectation per edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [33:0] exp, got;
        string tag;
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        got = {accQ, regA, regB, regC, portA, portB, portC, portD, carryFlag, zeroFlag};
        testsRun++;
        if (got !== exp) begin
          testsFail++;
          $display("FAIL %s state: got %h exp %h", tag, got, exp);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      testsFail++;
      finished = 1'b1;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; instrWord = 16'h0000; ramRdData = 4'h0;
    modelReset();
    issue(1, 16'h0000, 4'h0, "R1 reset");
    issue(1, 16'h0000, 4'h0, "R1 reset hold");
    // R2 immediate loads
    issue(0, 16'h0005, 4'h0, "R2 ldi acc");
    issue(0, 16'h1006, 4'h0, "R2 ldi ra");
    issue(0, 16'h2007, 4'h0, "R2 ldi rb");
    issue(0, 16'h300A, 4'h0, "R2 ldi rc");
    issue(0, 16'h0000, 4'h0, "R2 ldi acc zero");
    issue(0, 16'h1003, 4'h0, "R2 ldi ra keeps zf");
    // R3 nand variants
    issue(0, 16'h0105, 4'h0, "R3 nand imm");
    issue(0, 16'h1100, 4'h0, "R3 nand ra");
    issue(0, 16'h2100, 4'h0, "R3 nand rb");
    issue(0, 16'h3120, 4'h9, "R3 nand ram abs");
    issue(0, 16'h7100, 4'hF, "R3 nand ram indirect");
    issue(0, 16'h000F, 4'h0, "R3 setup");
    issue(0, 16'h010F, 4'h0, "R3 nand to zero");
    // R4 subtract
    issue(0, 16'h0002, 4'h0, "R4 setup");
    issue(0, 16'h0B05, 4'h0, "R4 sub borrow");
    issue(0, 16'h0B0D, 4'h0, "R4 sub to zero");
    issue(0, 16'h1B00, 4'h0, "R4 sub ra");
    issue(0, 16'h7B00, 4'h1, "R4 sub ram indirect");
    // R5 compare
    issue(0, 16'h0006, 4'h0, "R5 setup");
    issue(0, 16'h0806, 4'h0, "R5 cmp equal");
    issue(0, 16'h0807, 4'h0, "R5 cmp borrow");
    issue(0, 16'h2800, 4'h0, "R5 cmp rb");
    issue(0, 16'h38C3, 4'h2, "R5 cmp ram abs");
    // R6 loads into accumulator
    issue(0, 16'h0B07, 4'h0, "R6 make carry");
    issue(0, 16'h0230, 4'h0, "R6 ldw zero keeps cf");
    issue(0, 16'h4200, 4'hB, "R6 ldw indirect");
    issue(0, 16'h1300, 4'h0, "R6 lda ra");
    issue(0, 16'h2300, 4'h0, "R6 lda rb");
    issue(0, 16'h3300, 4'h0, "R6 lda rc");
    // R7 register loads from accumulator
    issue(0, 16'h0009, 4'h0, "R7 setup");
    issue(0, 16'h1700, 4'h0, "R7 ldr ra");
    issue(0, 16'h2700, 4'h0, "R7 ldr rb");
    issue(0, 16'h0000, 4'h0, "R7 setup zero");
    issue(0, 16'h3700, 4'h0, "R7 ldr rc flags hold");
    // R8 port outputs
    issue(0, 16'h0003, 4'h0, "R8 setup");
    issue(0, 16'h0405, 4'h0, "R8 outa imm");
    issue(0, 16'h1500, 4'h0, "R8 outb acc");
    issue(0, 16'h2600, 4'h0, "R8 outc ra");
    issue(0, 16'h39C3, 4'hE, "R8 outd ram abs");
    issue(0, 16'h7400, 4'h6, "R8 outa ram indirect");
    // R9 / R10 store and access type
    issue(0, 16'h0A1F, 4'h0, "R9 stw abs");
    issue(0, 16'h4A00, 4'h0, "R10 stw indirect");
    issue(0, 16'h3100, 4'h4, "R10 nand abs not indirect");
    issue(0, 16'h7600, 4'h8, "R10 outc indirect");
    // R11 no-operations
    issue(0, 16'h8005, 4'h0, "R11 ext bit set");
    issue(0, 16'h8A00, 4'h0, "R11 ext store");
    issue(0, 16'h0C05, 4'h0, "R11 opcode C");
    issue(0, 16'h0F05, 4'h0, "R11 opcode F");
    issue(0, 16'h0300, 4'h0, "R11 lda mod0");
    issue(0, 16'h0700, 4'h0, "R11 ldr mod0");
    issue(0, 16'h5100, 4'h0, "R11 nand mode mod1");
    issue(0, 16'h4005, 4'h0, "R11 ldi mode");
    issue(0, 16'h1A00, 4'h0, "R11 stw mod1");
    issue(0, 16'h6200, 4'h7, "R11 ldw mode mod2");
    issue(0, 16'h5400, 4'h0, "R11 out mode mod1");
    // reset again after activity
    issue(1, 16'h0000, 4'h0, "R1 reset after use");
    issue(0, 16'h0000, 4'h0, "R2 after reset");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule